// File: doc/BRIEF.md
# Receiver Wake-up Duty Sequencer

This block decides when a radio receiver is powered. It runs from a slow tick clock of roughly 32 kHz. A two-bit mode input selects one of three schemes. In the first, an external power-down pin drives the receiver directly. In the second, the receiver is switched on and off on a fixed period. In the third, the receiver polls: it wakes for a programmed span, and if it detects valid data it stays awake. Otherwise it sleeps for another programmed span and tries again. The on span and the off span are each 16-bit tick counts.

Raw data-valid indications from the detector are not trusted at once after power-up. A setup counter, set in ticks by a parameter, hides data-valid until the receiver has been powered for long enough. All inputs and outputs are plain control levels, so the block has no streaming interface and no back-pressure.

Top module: `wk_poll_seq`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `rx_en` and `dv_ok` are 0.
- R2: Mode encoding on `mode_i`: 2'b00 selects external control, 2'b01 selects polling, and any value with bit 1 set selects the periodic timer. Bit 0 has no effect when bit 1 is 1.
- R3: In external-control mode, `rx_en` equals the inverse of `ext_pdn` in the same cycle.
- R4: In timer mode, `rx_en` is high for exactly `on_ticks` cycles and then low for exactly `off_ticks` cycles, repeating. `dv_raw` has no effect on this cycle.
- R5: Polling mode uses the same on/off cycle as the timer. If `dv_ok` is high in any cycle of an on span, `rx_en` stays high from the next cycle onward until the mode changes.
- R6: `dv_ok` is high only when `rx_en` is high, `dv_raw` is high, and `rx_en` has been high without a break for at least `SETUP_TICKS` earlier cycles.
- R7: When `mode_i` differs from its value at the previous clock, the block goes to an idle state with `rx_en` low in the next cycle. After one idle cycle it restarts: either in external control, or at the start of an on span.
- R8: An `on_ticks` or `off_ticks` value of 0 behaves as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow tick clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | Scheme select (see R2) |
| on_ticks | input | CNT_W | Length of the awake span in ticks |
| off_ticks | input | CNT_W | Length of the sleep span in ticks |
| ext_pdn | input | 1 | External power-down, active high, used in external-control mode |
| dv_raw | input | 1 | Unfiltered data-valid from the detector |
| rx_en | output | 1 | Receiver power enable |
| dv_ok | output | 1 | Data-valid after the setup mask |

## Verification
The checker tests the following on every cycle:
- the setup mask on `dv_ok`, including the count of powered cycles before it;
- the pin-follow behaviour of external-control mode;
- the forced power-off after a mode change;
- the latch-awake behaviour after a trusted detection while polling.

The exact lengths of the on and off spans, the handling of zero counts, and the restart order after idle are shown only by the bench scenarios, where the reference model runs alongside the design.

// File: rtl/wk_pkg.sv
package wk_pkg;
  typedef enum logic [2:0] {
    WK_IDLE  = 3'd0,
    WK_SLAVE = 3'd1,
    WK_ON    = 3'd2,
    WK_OFF   = 3'd3,
    WK_HOLD  = 3'd4
  } wk_state_e;

  function automatic logic mode_is_ext(input logic [1:0] m);
    return m == 2'b00;
  endfunction

  function automatic logic mode_is_poll(input logic [1:0] m);
    return m == 2'b01;
  endfunction
endpackage

// File: rtl/wk_span_ctr.sv
module wk_span_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             last
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt;

  // a zero span is stretched to one tick
  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt <= ONE;
    else if (load)
      cnt <= (load_val == '0) ? ONE : load_val;
    else if (dec && cnt > ONE)
      cnt <= cnt - ONE;
  end

  assign last = (cnt <= ONE);
endmodule

// File: rtl/wk_setup_mask.sv
module wk_setup_mask #(
  parameter int SETUP_TICKS = 84
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr,
  input  logic raw,
  output logic dv_ok
);
  localparam int SW = $clog2(SETUP_TICKS + 2);
  localparam logic [SW-1:0] LIMIT = SW'(SETUP_TICKS);

  logic [SW-1:0] elapsed;

  always_ff @(posedge clk) begin
    if (!rst_n || !pwr)
      elapsed <= '0;
    else if (elapsed < LIMIT)
      elapsed <= elapsed + SW'(1);
  end

  assign dv_ok = pwr && raw && (elapsed == LIMIT);
endmodule

// File: rtl/wk_poll_seq.sv
module wk_poll_seq #(
  parameter int CNT_W       = 16,
  parameter int SETUP_TICKS = 84
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_i,
  input  logic [CNT_W-1:0] on_ticks,
  input  logic [CNT_W-1:0] off_ticks,
  input  logic             ext_pdn,
  input  logic             dv_raw,
  output logic             rx_en,
  output logic             dv_ok
);
  import wk_pkg::*;

  wk_state_e  state, state_nx;
  logic [1:0] mode_q;
  logic       mode_chg;
  logic       span_last;
  logic       span_load;
  logic       span_dec;
  logic [CNT_W-1:0] span_val;
  logic       keep_awake;

  assign mode_chg   = (mode_i != mode_q);
  assign keep_awake = mode_is_poll(mode_q) && dv_ok;

  always_comb begin
    unique case (state)
      WK_SLAVE:        rx_en = !ext_pdn;
      WK_ON, WK_HOLD:  rx_en = 1'b1;
      default:         rx_en = 1'b0;
    endcase
  end

  always_comb begin
    state_nx  = state;
    span_load = 1'b0;
    span_dec  = 1'b0;
    span_val  = on_ticks;
    if (mode_chg) begin
      state_nx = WK_IDLE;
    end else begin
      unique case (state)
        WK_IDLE: begin
          if (mode_is_ext(mode_q)) begin
            state_nx = WK_SLAVE;
          end else begin
            state_nx  = WK_ON;
            span_load = 1'b1;
          end
        end
        WK_ON: begin
          span_dec = 1'b1;
          if (keep_awake) begin
            state_nx = WK_HOLD;
          end else if (span_last) begin
            state_nx  = WK_OFF;
            span_load = 1'b1;
            span_val  = off_ticks;
          end
        end
        WK_OFF: begin
          span_dec = 1'b1;
          if (span_last) begin
            state_nx  = WK_ON;
            span_load = 1'b1;
          end
        end
        default: state_nx = state;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= WK_IDLE;
      mode_q <= 2'b00;
    end else begin
      state  <= state_nx;
      mode_q <= mode_i;
    end
  end

  wk_span_ctr #(.CNT_W(CNT_W)) u_span (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (span_load),
    .load_val (span_val),
    .dec      (span_dec),
    .last     (span_last)
  );

  wk_setup_mask #(.SETUP_TICKS(SETUP_TICKS)) u_mask (
    .clk   (clk),
    .rst_n (rst_n),
    .pwr   (rx_en),
    .raw   (dv_raw),
    .dv_ok (dv_ok)
  );
endmodule

// File: rtl/wk_poll_seq_chk.sv
module wk_poll_seq_chk #(
  parameter int SETUP_TICKS = 84
) (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode_i,
  input logic       ext_pdn,
  input logic       dv_raw,
  input logic       rx_en,
  input logic       dv_ok
);
  int unsigned run;

  always_ff @(posedge clk) begin
    if (!rst_n || !rx_en)
      run <= 0;
    else if (run < SETUP_TICKS + 1)
      run <= run + 1;
  end

  a_r1_off_after_reset: assert property (@(posedge clk)
    $rose(rst_n) |-> (!rx_en && !dv_ok));

  a_r6_mask_gate: assert property (@(posedge clk) disable iff (!rst_n)
    dv_ok |-> (rx_en && dv_raw));

  a_r6_setup_elapsed: assert property (@(posedge clk) disable iff (!rst_n)
    dv_ok |-> (run >= SETUP_TICKS));

  a_r3_ext_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b00 && $past(mode_i) == 2'b00 && $past(mode_i, 2) == 2'b00
     && $past(rst_n) && $past(rst_n, 2)) |-> (rx_en == !ext_pdn));

  a_r7_mode_change_off: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && mode_i != $past(mode_i)) |=> !rx_en);

  a_r5_stay_awake: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b01 && $past(mode_i) == 2'b01 && $past(mode_i, 2) == 2'b01
     && $past(rst_n) && $past(rst_n, 2) && $past(dv_ok)) |-> rx_en);
endmodule

bind wk_poll_seq wk_poll_seq_chk #(.SETUP_TICKS(SETUP_TICKS)) u_chk (.*);

// File: tb/wk_poll_seq_tb.sv
module wk_poll_seq_tb;
  localparam int CNT_W = 16;
  localparam int SETUP = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [1:0]       mode_i = 2'b00;
  logic [CNT_W-1:0] on_ticks = '0;
  logic [CNT_W-1:0] off_ticks = '0;
  logic             ext_pdn = 1'b1;
  logic             dv_raw = 1'b0;
  logic             rx_en, dv_ok;

  int    n_chk = 0, n_fail = 0;
  string tag = "R1";
  bit    done = 0;

  always #2 clk = ~clk;

  wk_poll_seq #(.CNT_W(CNT_W), .SETUP_TICKS(SETUP)) u_dut (.*);

  // behavioural model: 0 idle, 1 ext, 2 on, 3 off, 4 hold
  int         m_st = 0, m_cnt = 1, m_su = 0;
  logic [1:0] m_mode = 2'b00;

  function automatic int ld(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic bit m_rx();
    if (m_st == 1) return !ext_pdn;
    return (m_st == 2 || m_st == 4);
  endfunction

  function automatic bit m_dv();
    return m_rx() && dv_raw && (m_su == SETUP);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 1; m_su = 0; m_mode = 2'b00;
    end else begin
      bit rx, dv;
      rx = m_rx();
      dv = m_dv();
      if (!rx) m_su = 0;
      else if (m_su < SETUP) m_su++;
      if (mode_i != m_mode) begin
        m_mode = mode_i;
        m_st = 0;
      end else begin
        case (m_st)
          0: if (m_mode == 2'b00) m_st = 1;
             else begin m_st = 2; m_cnt = ld(on_ticks); end
          2: if (m_mode == 2'b01 && dv) m_st = 4;
             else if (m_cnt <= 1) begin m_st = 3; m_cnt = ld(off_ticks); end
             else m_cnt--;
          3: if (m_cnt <= 1) begin m_st = 2; m_cnt = ld(on_ticks); end
             else m_cnt--;
          default: ;
        endcase
      end
    end
  end

  task automatic check(input string req, input bit act, input bit exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(tag, rx_en, m_rx(), "rx_en");
      check(tag, dv_ok, m_dv(), "dv_ok");
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic set_mode(input logic [1:0] m, input int on, input int off);
    on_ticks = CNT_W'(on);
    off_ticks = CNT_W'(off);
    mode_i = m;
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(4 * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    int highs;
    step(3);
    @(negedge clk);
    check("R1", rx_en, 1'b0, "rx_en in reset");
    check("R1", dv_ok, 1'b0, "dv_ok in reset");
    step(0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", rx_en, 1'b0, "rx_en after release");

    // R3, R6: external control
    tag = "R3"; step(2);
    ext_pdn = 1'b0; dv_raw = 1'b1; step(3);
    tag = "R6"; step(6);
    ext_pdn = 1'b1; step(2);
    ext_pdn = 1'b0; step(2);
    dv_raw = 1'b0; step(2);

    // R4: timer, dv ignored
    tag = "R4"; dv_raw = 1'b1; set_mode(2'b10, 5, 3);
    step(1);
    highs = 0;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      if (rx_en) highs++;
      step(1);
    end
    // idle 1 then on5 off3 on5 off2 -> 10 high in 16
    n_chk++;
    if (highs != 10) begin
      n_fail++;
      $display("FAIL R4 high count: actual %0d expected 10", highs);
    end
    step(14);

    // R2: bit0 ignored when bit1 set
    tag = "R2"; set_mode(2'b11, 2, 4); step(20);

    // R7: change mode mid on span
    tag = "R7"; set_mode(2'b10, 6, 2); step(3);
    mode_i = 2'b11; step(1);
    @(negedge clk);
    check("R7", rx_en, 1'b0, "rx_en after change");
    step(10);

    // R6: polling with on span shorter than setup never holds
    tag = "R6"; dv_raw = 1'b1; set_mode(2'b01, 3, 2); step(25);

    // R5: polling, detection latches awake
    tag = "R5"; dv_raw = 1'b0; set_mode(2'b10, 1, 1); step(2);
    set_mode(2'b01, 8, 3); step(20);
    dv_raw = 1'b1; step(12);
    dv_raw = 1'b0; step(15);
    @(negedge clk);
    check("R5", rx_en, 1'b1, "rx_en held awake");
    step(1);

    // R8: zero spans
    tag = "R8"; set_mode(2'b10, 0, 0); step(1);
    highs = 0;
    for (int i = 0; i < 9; i++) begin
      @(negedge clk);
      if (rx_en) highs++;
      step(1);
    end
    // idle then alternating 1/1 starting high -> 4 of 9
    n_chk++;
    if (highs != 4) begin
      n_fail++;
      $display("FAIL R8 high count: actual %0d expected 4", highs);
    end
    tag = "R8"; set_mode(2'b01, 0, 5); step(20);

    finish_run();
  end
endmodule